// File: doc/BRIEF.md
# Split-Read Completion Tracker with Write Forwarding

This block sits between a requester and a memory read queue. Each read request gives a start address, a byte length and a requester tag. The block cuts the request into bursts at burst-size boundaries. For each burst it searches a small store of pending writes. A burst whose data is already held there is counted as serviced at once. Any other burst is handed to the read queue together with a context word, and that word comes back with the memory return.

Reads of two or more bursts take a slot in a completion table. The slot counts the bursts that have been serviced, whether forwarded or returned from memory. The block sends exactly one response, carrying the requester tag, when that count reaches the burst total. A read of a single burst takes no slot and is answered directly. The block also counts the read-queue entries in flight. It refuses a request that would overflow them, and it raises a one-cycle retry pulse when space frees.

Top module: `split_read_tracker`

## Requirements
- R1: After reset, no response, read-queue burst or retry pulse is presented, and `rq_ready` is high.
- R2: `rq_len_m1` holds the byte length minus one. A request of length L at address A makes ceil(((A mod B) + L) / B) bursts, where B is BURST_BYTES. They are handled in ascending order. The first starts at A and later ones start on B-aligned addresses. Each burst runs to the next boundary or to the end of the request, and `rdq_size` is its length in bytes.
- R3: A burst is forwarded only when a valid write entry has exactly the burst's start address and a size of at least the burst's size. A write entry whose address differs, or whose size is smaller, does not forward.
- R4: A forwarded burst never appears on the read-queue port. A burst presented with `rdq_valid` stays presented, with the same address, size and context, until `rdq_ready`.
- R5: When every burst of a request is forwarded, its response is issued without any read-queue burst and without any memory return.
- R6: For a read of two or more bursts, the serviced count starts with the forwarded bursts and rises by one on each memory return. The response is issued once, when the count equals the burst total, and never earlier.
- R7: A read of one burst uses no slot. Its burst context is {1'b0, tag}, and it is answered on its own return. A split read's context is {1'b1, slot index}, with the flag in the context MSB.
- R8: A read of two or more bursts is stalled (`rq_ready` low) while every slot is busy. A read of one burst is still accepted at that time.
- R9: Occupancy counts bursts handed to the read queue and not yet returned. A request is refused while occupancy plus its burst count exceeds RD_CAP, and a request that fills the count exactly to RD_CAP is accepted.
- R10: A refusal for lack of read-queue space marks a retry as pending. The next memory return raises `rd_retry` for that cycle and clears the mark, so later returns raise nothing.
- R11: Responses leave in the order their final bursts complete. A response is held, with the same tag, until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wq_set | input | 1 | Write a pending-write entry |
| wq_set_idx | input | 2 | Entry index to write |
| wq_set_addr | input | 16 | Start address of the pending write |
| wq_set_size | input | 6 | Byte size of the pending write |
| wq_clr | input | 1 | Invalidate a pending-write entry |
| wq_clr_idx | input | 2 | Entry index to invalidate |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted this cycle |
| rq_addr | input | 16 | Request start address |
| rq_len_m1 | input | 8 | Request length in bytes minus one |
| rq_tag | input | 4 | Requester tag |
| rd_retry | output | 1 | One-cycle retry pulse after a space refusal |
| rdq_valid | output | 1 | Burst presented to the read queue |
| rdq_ready | input | 1 | Read queue takes the burst |
| rdq_addr | output | 16 | Burst start address |
| rdq_size | output | 6 | Burst size in bytes |
| rdq_ctx | output | 5 | Burst context (split flag, index) |
| ret_valid | input | 1 | Memory return valid |
| ret_ready | output | 1 | Memory return accepted |
| ret_ctx | input | 5 | Context of the returned burst |
| rsp_valid | output | 1 | Response to requester valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_tag | output | 4 | Tag of the completed request |

## Verification
Some rules are checked on every cycle. A presented burst or response must hold until it is taken, and a burst on the read-queue port has a non-zero size no larger than a burst. Occupancy never exceeds its cap. A live slot's count stays below its burst total, and a memory event only ever targets a live slot. The bench scenarios cover what a per-cycle check cannot see. They show the burst addresses and sizes of unaligned requests and that both the address and the size conditions of the forwarding rule are needed. They show that a split read's response waits for its last burst, including when returns arrive out of order. They also cover the ordering across interleaved requests, the slot-exhaustion and capacity stalls, and the single retry pulse after a refusal.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [0:0] {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/srt_wq_cam.sv
module srt_wq_cam #(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 6,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [SZ_W-1:0]   set_size,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [SZ_W-1:0]   q_size,
  output logic              hit
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q, v_nx;
    logic [ADDR_W-1:0] a_q;
    logic [SZ_W-1:0]   s_q;
    logic              wr_this;

    assign wr_this = set_en && (set_idx == IDX_W'(i));

    always_comb begin
      v_nx = v_q;
      if (clr_en && (clr_idx == IDX_W'(i))) v_nx = 1'b0;
      if (wr_this) v_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_nx;
    end

    always_ff @(posedge clk) begin
      if (wr_this) begin
        a_q <= set_addr;
        s_q <= set_size;
      end
    end

    assign match[i] = v_q && (a_q == q_addr) && (s_q >= q_size);
  end

  assign hit = |match;
endmodule

// File: rtl/srt_walker.sv
module srt_walker
  import srt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int OFF_W  = 5,
  parameter int SZ_W   = 6,
  parameter int CTX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LEN_W-1:0]  st_len_m1,
  input  logic [CTX_W-1:0]  st_ctx,
  output logic              busy,
  output logic [ADDR_W-1:0] q_addr,
  output logic [SZ_W-1:0]   q_size,
  input  logic              hit,
  input  logic              may_fwd,
  output logic              fwd_want,
  output logic              fwd_fire,
  output logic [CTX_W-1:0]  cur_ctx,
  output logic              rdq_valid,
  input  logic              rdq_ready,
  output logic [ADDR_W-1:0] rdq_addr,
  output logic [SZ_W-1:0]   rdq_size,
  output logic [CTX_W-1:0]  rdq_ctx
);
  localparam int BURST_BYTES = 1 << OFF_W;
  localparam int PW = ADDR_W + 1;

  walk_st_e       st_q, st_nx;
  logic [PW-1:0]  cur_q, cur_nx, end_q, end_nx;
  logic [CTX_W-1:0] ctx_q, ctx_nx;
  logic           lock_q, lock_nx;
  logic [PW-1:0]  bound, lim;
  logic           running, step, last;

  assign running = (st_q == WK_RUN);
  assign bound   = {cur_q[PW-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};
  assign lim     = (bound < end_q) ? bound : end_q;
  assign last    = (lim == end_q);

  assign q_addr    = cur_q[ADDR_W-1:0];
  assign q_size    = SZ_W'(lim - cur_q);
  assign fwd_want  = running && !lock_q && hit;
  assign fwd_fire  = fwd_want && may_fwd;
  assign rdq_valid = running && (lock_q || !hit);
  assign rdq_addr  = cur_q[ADDR_W-1:0];
  assign rdq_size  = q_size;
  assign rdq_ctx   = ctx_q;
  assign cur_ctx   = ctx_q;
  assign busy      = running;
  assign step      = fwd_fire || (rdq_valid && rdq_ready);

  always_comb begin
    st_nx   = st_q;
    cur_nx  = cur_q;
    end_nx  = end_q;
    ctx_nx  = ctx_q;
    lock_nx = lock_q;
    if (!running) begin
      lock_nx = 1'b0;
      if (start) begin
        st_nx  = WK_RUN;
        cur_nx = {1'b0, st_addr};
        end_nx = {1'b0, st_addr} + PW'(st_len_m1) + PW'(1);
        ctx_nx = st_ctx;
      end
    end else if (step) begin
      cur_nx  = lim;
      lock_nx = 1'b0;
      if (last) st_nx = WK_IDLE;
    end else if (rdq_valid) begin
      lock_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      lock_q <= lock_nx;
    end
  end

  always_ff @(posedge clk) begin
    cur_q <= cur_nx;
    end_q <= end_nx;
    ctx_q <= ctx_nx;
  end

  AST_RDQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rdq_valid && !rdq_ready |=> rdq_valid && $stable(rdq_addr) && $stable(rdq_size) && $stable(rdq_ctx)); // R4

  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rdq_valid |-> (rdq_size != '0) && (rdq_size <= SZ_W'(BURST_BYTES))); // R2
endmodule

// File: rtl/srt_slot_table.sv
module srt_slot_table #(
  parameter int NSLOT = 4,
  parameter int TAG_W = 4,
  parameter int NB_W  = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [NB_W-1:0]   alloc_need,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_idx,
  input  logic              ev_en,
  input  logic [SLOT_W-1:0] ev_idx,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag
);
  logic             busy_q [NSLOT];
  logic [NB_W-1:0]  serv_q [NSLOT];
  logic [NB_W-1:0]  need_q [NSLOT];
  logic [TAG_W-1:0] tag_q  [NSLOT];

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  assign done     = ev_en && busy_q[ev_idx] &&
                    ((serv_q[ev_idx] + NB_W'(1)) == need_q[ev_idx]);
  assign done_tag = tag_q[ev_idx];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic            busy_nx;
    logic [NB_W-1:0] serv_nx;
    logic            take, hit_ev;

    assign take   = alloc_en && (free_idx == SLOT_W'(i));
    assign hit_ev = ev_en && (ev_idx == SLOT_W'(i));

    always_comb begin
      busy_nx = busy_q[i];
      serv_nx = serv_q[i];
      if (take) begin
        busy_nx = 1'b1;
        serv_nx = '0;
      end else if (hit_ev) begin
        serv_nx = serv_q[i] + NB_W'(1);
        if (done) busy_nx = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[i] <= 1'b0;
        serv_q[i] <= '0;
      end else begin
        busy_q[i] <= busy_nx;
        serv_q[i] <= serv_nx;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        need_q[i] <= alloc_need;
        tag_q[i]  <= alloc_tag;
      end
    end

    AST_SERV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[i] |-> serv_q[i] < need_q[i]); // R6
  end

  AST_EVT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en |-> busy_q[ev_idx]); // R6
endmodule

// File: rtl/split_read_tracker.sv
module split_read_tracker #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 8,
  parameter int BURST_BYTES = 32,
  parameter int WQ_DEPTH    = 4,
  parameter int NSLOT       = 4,
  parameter int TAG_W       = 4,
  parameter int RD_CAP      = 8,
  localparam int OFF_W  = $clog2(BURST_BYTES),
  localparam int SZ_W   = $clog2(BURST_BYTES + 1),
  localparam int WQI_W  = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int IDX_W  = (TAG_W > SLOT_W) ? TAG_W : SLOT_W,
  localparam int CTX_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wq_set,
  input  logic [WQI_W-1:0]  wq_set_idx,
  input  logic [ADDR_W-1:0] wq_set_addr,
  input  logic [SZ_W-1:0]   wq_set_size,
  input  logic              wq_clr,
  input  logic [WQI_W-1:0]  wq_clr_idx,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [LEN_W-1:0]  rq_len_m1,
  input  logic [TAG_W-1:0]  rq_tag,
  output logic              rd_retry,
  output logic              rdq_valid,
  input  logic              rdq_ready,
  output logic [ADDR_W-1:0] rdq_addr,
  output logic [SZ_W-1:0]   rdq_size,
  output logic [CTX_W-1:0]  rdq_ctx,
  input  logic              ret_valid,
  output logic              ret_ready,
  input  logic [CTX_W-1:0]  ret_ctx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int MAXB  = (2 * BURST_BYTES - 2 + (1 << LEN_W)) / BURST_BYTES;
  localparam int NB_W  = $clog2(MAXB + 1);
  localparam int OCC_W = $clog2(RD_CAP + 1);
  localparam int SUM_W = ((OCC_W > NB_W) ? OCC_W : NB_W) + 1;
  localparam int RAW_W = LEN_W + OFF_W + 2;

  logic              w_busy, fwd_want, fwd_fire, cam_hit;
  logic [ADDR_W-1:0] q_addr;
  logic [SZ_W-1:0]   q_size;
  logic [CTX_W-1:0]  cur_ctx, st_ctx, ev_ctx;
  logic              free_any, done;
  logic [SLOT_W-1:0] free_idx;
  logic [TAG_W-1:0]  done_tag, emit_tag;
  logic [NB_W-1:0]   nb;
  logic [RAW_W-1:0]  nb_raw;
  logic              one_burst, room, rq_fire, refuse;
  logic              rdq_fire, ret_fire, ev_any, ev_split, emit, out_free;
  logic [OCC_W-1:0]  occ_q, occ_nx;
  logic              pend_q, pend_nx;
  logic              rsp_v_q, rsp_v_nx;
  logic [TAG_W-1:0]  rsp_t_q, rsp_t_nx;

  // burst count of the incoming request
  assign nb_raw    = RAW_W'(rq_addr[OFF_W-1:0]) + RAW_W'(rq_len_m1) + RAW_W'(BURST_BYTES);
  assign nb        = NB_W'(nb_raw >> OFF_W);
  assign one_burst = (nb == NB_W'(1));
  assign room      = (SUM_W'(occ_q) + SUM_W'(nb)) <= SUM_W'(RD_CAP);

  assign rq_ready = !w_busy && room && (one_burst || free_any);
  assign rq_fire  = rq_valid && rq_ready;
  assign refuse   = rq_valid && !w_busy && !room;
  assign st_ctx   = one_burst ? {1'b0, IDX_W'(rq_tag)} : {1'b1, IDX_W'(free_idx)};

  assign out_free  = !rsp_v_q || rsp_ready;
  assign ret_ready = out_free && !fwd_want;
  assign ret_fire  = ret_valid && ret_ready;
  assign rdq_fire  = rdq_valid && rdq_ready;
  assign rd_retry  = ret_fire && pend_q;

  // one completion event per cycle: a forwarded burst or a memory return
  assign ev_any   = fwd_fire || ret_fire;
  assign ev_ctx   = fwd_fire ? cur_ctx : ret_ctx;
  assign ev_split = ev_ctx[CTX_W-1];
  assign emit     = ev_any && (!ev_split || done);
  assign emit_tag = ev_split ? done_tag : ev_ctx[TAG_W-1:0];

  srt_wq_cam #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .DEPTH(WQ_DEPTH)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .set_en(wq_set), .set_idx(wq_set_idx), .set_addr(wq_set_addr), .set_size(wq_set_size),
    .clr_en(wq_clr), .clr_idx(wq_clr_idx),
    .q_addr(q_addr), .q_size(q_size), .hit(cam_hit)
  );

  srt_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .SZ_W(SZ_W), .CTX_W(CTX_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(rq_fire), .st_addr(rq_addr), .st_len_m1(rq_len_m1), .st_ctx(st_ctx),
    .busy(w_busy), .q_addr(q_addr), .q_size(q_size), .hit(cam_hit),
    .may_fwd(out_free), .fwd_want(fwd_want), .fwd_fire(fwd_fire), .cur_ctx(cur_ctx),
    .rdq_valid(rdq_valid), .rdq_ready(rdq_ready), .rdq_addr(rdq_addr),
    .rdq_size(rdq_size), .rdq_ctx(rdq_ctx)
  );

  srt_slot_table #(.NSLOT(NSLOT), .TAG_W(TAG_W), .NB_W(NB_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(rq_fire && !one_burst), .alloc_need(nb), .alloc_tag(rq_tag),
    .free_any(free_any), .free_idx(free_idx),
    .ev_en(ev_any && ev_split), .ev_idx(ev_ctx[SLOT_W-1:0]),
    .done(done), .done_tag(done_tag)
  );

  always_comb begin
    occ_nx = occ_q;
    if (rdq_fire && !ret_fire)      occ_nx = occ_q + OCC_W'(1);
    else if (ret_fire && !rdq_fire) occ_nx = occ_q - OCC_W'(1);
    pend_nx  = (pend_q && !ret_fire) || refuse;
    rsp_v_nx = rsp_v_q;
    rsp_t_nx = rsp_t_q;
    if (emit) begin
      rsp_v_nx = 1'b1;
      rsp_t_nx = emit_tag;
    end else if (rsp_ready) begin
      rsp_v_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      pend_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      occ_q   <= occ_nx;
      pend_q  <= pend_nx;
      rsp_v_q <= rsp_v_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) rsp_t_q <= rsp_t_nx;
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_tag   = rsp_t_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag)); // R11

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(RD_CAP)); // R9
endmodule

// File: tb/sim_split_read_tracker.sv
`timescale 1ns/1ps
module sim_split_read_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wq_set = 0, wq_clr = 0;
  logic [1:0] wq_set_idx = 0, wq_clr_idx = 0;
  logic [15:0] wq_set_addr = 0;
  logic [5:0] wq_set_size = 0;
  logic rq_valid = 0;
  logic rq_ready;
  logic [15:0] rq_addr = 0;
  logic [7:0] rq_len_m1 = 0;
  logic [3:0] rq_tag = 0;
  logic rd_retry, rdq_valid;
  logic rdq_ready = 1;
  logic [15:0] rdq_addr;
  logic [5:0] rdq_size;
  logic [4:0] rdq_ctx;
  logic ret_valid = 0;
  logic ret_ready;
  logic [4:0] ret_ctx = 0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [3:0] rsp_tag;

  always #2 clk = ~clk;

  split_read_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .wq_set(wq_set), .wq_set_idx(wq_set_idx), .wq_set_addr(wq_set_addr), .wq_set_size(wq_set_size),
    .wq_clr(wq_clr), .wq_clr_idx(wq_clr_idx),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len_m1(rq_len_m1), .rq_tag(rq_tag),
    .rd_retry(rd_retry),
    .rdq_valid(rdq_valid), .rdq_ready(rdq_ready), .rdq_addr(rdq_addr), .rdq_size(rdq_size), .rdq_ctx(rdq_ctx),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_ctx(ret_ctx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag)
  );

  int n_tests = 0, n_fail = 0;
  int rsp_cnt = 0, retry_seen = 0, iss_n = 0;
  int exp_q[$];
  logic [15:0] iss_addr [64];
  logic [5:0]  iss_size [64];
  logic [4:0]  iss_ctx  [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // monitors sample 1 ns after the falling edge
  always begin
    @(negedge clk); #1;
    if (rdq_valid && rdq_ready && iss_n < 64) begin
      iss_addr[iss_n] = rdq_addr; iss_size[iss_n] = rdq_size; iss_ctx[iss_n] = rdq_ctx;
      iss_n++;
    end
    if (rd_retry) retry_seen++;
    if (rsp_valid && rsp_ready) begin
      rsp_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected response", int'(rsp_tag), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(rsp_tag) == e, "R11 response tag/order", int'(rsp_tag), e);
      end
    end
  end

  task automatic settle(input int n); repeat (n) @(negedge clk); endtask

  task automatic wq_put(input int idx, input int a, input int s);
    @(negedge clk); wq_set = 1; wq_set_idx = 2'(idx); wq_set_addr = 16'(a); wq_set_size = 6'(s);
    @(negedge clk); wq_set = 0;
  endtask

  task automatic wq_drop(input int idx);
    @(negedge clk); wq_clr = 1; wq_clr_idx = 2'(idx);
    @(negedge clk); wq_clr = 0;
  endtask

  task automatic send_req(input int a, input int l, input int t);
    @(negedge clk); rq_valid = 1; rq_addr = 16'(a); rq_len_m1 = 8'(l); rq_tag = 4'(t); #1;
    while (!rq_ready) begin @(negedge clk); #1; end
    @(negedge clk); rq_valid = 0;
    settle(4);
  endtask

  task automatic ret(input int k);
    @(negedge clk); ret_valid = 1; ret_ctx = iss_ctx[k]; #1;
    while (!ret_ready) begin @(negedge clk); #1; end
    @(negedge clk); ret_valid = 0;
    settle(2);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int b, c;
    settle(3);
    rst_n = 1;
    settle(1); #1;
    check(rq_ready == 1, "R1 rq_ready", rq_ready, 1);
    check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    check(rdq_valid == 0, "R1 rdq_valid", rdq_valid, 0);
    check(rd_retry == 0, "R1 rd_retry", rd_retry, 0);

    // single burst, read-queue stall
    rdq_ready = 0;
    @(negedge clk); rq_valid = 1; rq_addr = 16'h0040; rq_len_m1 = 15; rq_tag = 3;
    @(negedge clk); rq_valid = 0;
    settle(2); #1;
    check(rdq_valid == 1, "R4 burst presented", rdq_valid, 1);
    check(rdq_addr == 16'h0040, "R2 single addr", rdq_addr, 16'h40);
    check(rdq_size == 16, "R2 single size", rdq_size, 16);
    check(rdq_ctx == 5'h03, "R7 single ctx", rdq_ctx, 3);
    settle(2); #1;
    check(rdq_valid == 1 && rdq_addr == 16'h0040, "R4 burst held", rdq_addr, 16'h40);
    rdq_ready = 1;
    settle(2);
    check(iss_n == 1, "R7 single issued", iss_n, 1);
    exp_q.push_back(3);
    ret(0);
    check(rsp_cnt == 1, "R7 single response", rsp_cnt, 1);

    // forward hit, response held
    wq_put(0, 16'h0080, 32);
    rsp_ready = 0;
    b = iss_n;
    exp_q.push_back(5);
    send_req(16'h0080, 31, 5); #1;
    check(rsp_valid == 1 && rsp_tag == 5, "R11 response presented", rsp_tag, 5);
    settle(2); #1;
    check(rsp_valid == 1 && rsp_tag == 5, "R11 response held", rsp_tag, 5);
    rsp_ready = 1;
    settle(2);
    check(rsp_cnt == 2, "R5 forwarded single answered", rsp_cnt, 2);
    check(iss_n == b, "R4 forwarded not issued", iss_n, b);
    exp_q.push_back(8);
    send_req(16'h0080, 3, 8);
    check(rsp_cnt == 3 && iss_n == b, "R3 larger entry covers", rsp_cnt, 3);

    // size too small
    wq_put(1, 16'h00A0, 8);
    send_req(16'h00A0, 15, 6);
    check(iss_n == b + 1 && iss_addr[b] == 16'h00A0, "R3 small entry no forward", iss_n, b + 1);
    exp_q.push_back(6); ret(b);
    // address off by one
    wq_put(2, 16'h00C1, 32);
    send_req(16'h00C0, 3, 7);
    check(iss_n == b + 2 && iss_addr[b+1] == 16'h00C0, "R3 address mismatch no forward", iss_n, b + 2);
    exp_q.push_back(7); ret(b + 1);
    check(rsp_cnt == 5, "R7 returns answered", rsp_cnt, 5);
    wq_drop(0); wq_drop(1); wq_drop(2);

    // unaligned split read, out-of-order returns
    b = iss_n;
    send_req(16'h0105, 69, 9);
    check(iss_n == b + 3, "R2 burst count", iss_n - b, 3);
    check(iss_addr[b] == 16'h0105 && iss_size[b] == 27, "R2 first burst", iss_size[b], 27);
    check(iss_addr[b+1] == 16'h0120 && iss_size[b+1] == 32, "R2 middle burst", iss_size[b+1], 32);
    check(iss_addr[b+2] == 16'h0140 && iss_size[b+2] == 11, "R2 last burst", iss_size[b+2], 11);
    check(iss_ctx[b][4] == 1'b1, "R7 split ctx flag", iss_ctx[b][4], 1);
    c = rsp_cnt;
    ret(b + 2); ret(b);
    check(rsp_cnt == c, "R6 no early response", rsp_cnt, c);
    exp_q.push_back(9); ret(b + 1);
    check(rsp_cnt == c + 1, "R6 response on final return", rsp_cnt, c + 1);

    // split with middle burst forwarded
    wq_put(0, 16'h0220, 32);
    b = iss_n;
    send_req(16'h0205, 69, 10);
    check(iss_n == b + 2 && iss_addr[b+1] == 16'h0240, "R6 partial forward issues two", iss_n - b, 2);
    c = rsp_cnt;
    ret(b);
    check(rsp_cnt == c, "R6 partial forward waits", rsp_cnt, c);
    exp_q.push_back(10); ret(b + 1);
    check(rsp_cnt == c + 1, "R6 partial forward completes", rsp_cnt, c + 1);

    // split fully forwarded
    wq_put(0, 16'h0300, 32); wq_put(1, 16'h0320, 32);
    b = iss_n; c = rsp_cnt;
    exp_q.push_back(11);
    send_req(16'h0300, 63, 11);
    check(iss_n == b && rsp_cnt == c + 1, "R5 all forwarded split", rsp_cnt, c + 1);
    wq_drop(0); wq_drop(1);

    // completion order across two split reads
    b = iss_n; c = rsp_cnt;
    send_req(16'h0400, 63, 12);
    send_req(16'h0500, 63, 13);
    exp_q.push_back(13); exp_q.push_back(12);
    ret(b + 2); ret(b + 3); ret(b); ret(b + 1);
    check(rsp_cnt == c + 2, "R11 two responses", rsp_cnt, c + 2);

    // slot exhaustion
    wq_put(0, 16'h0600, 32); wq_put(1, 16'h0640, 32);
    wq_put(2, 16'h0680, 32); wq_put(3, 16'h06C0, 32);
    b = iss_n;
    for (int i = 0; i < 4; i++) send_req(16'h0600 + 16'h40 * i, 63, i + 1);
    check(iss_n == b + 4, "R8 four split reads issued", iss_n - b, 4);
    @(negedge clk); rq_valid = 1; rq_addr = 16'h0700; rq_len_m1 = 63; rq_tag = 14;
    settle(2); #1;
    check(rq_ready == 0, "R8 split stalled without slot", rq_ready, 0);
    @(negedge clk); rq_valid = 0;
    send_req(16'h0800, 7, 15);
    check(iss_n == b + 5, "R8 single accepted without slot", iss_n - b, 5);
    for (int i = 0; i < 4; i++) exp_q.push_back(i + 1);
    exp_q.push_back(15);
    for (int i = 0; i < 5; i++) ret(b + i);
    check(retry_seen == 0, "R10 no retry without refusal", retry_seen, 0);
    for (int i = 0; i < 4; i++) wq_drop(i);

    // read-side capacity and retry
    b = iss_n;
    for (int i = 0; i < 8; i++) send_req(16'h0900 + 16'h20 * i, 31, i);
    check(iss_n == b + 8, "R9 fill to capacity accepted", iss_n - b, 8);
    @(negedge clk); rq_valid = 1; rq_addr = 16'h0A00; rq_len_m1 = 0; rq_tag = 9;
    settle(2); #1;
    check(rq_ready == 0, "R9 refused over capacity", rq_ready, 0);
    @(negedge clk); rq_valid = 0;
    settle(1);
    check(retry_seen == 0, "R10 no pulse before return", retry_seen, 0);
    for (int i = 0; i < 8; i++) exp_q.push_back(i);
    ret(b);
    check(retry_seen == 1, "R10 retry on return", retry_seen, 1);
    ret(b + 1);
    check(retry_seen == 1, "R10 retry cleared", retry_seen, 1);
    for (int i = 2; i < 8; i++) ret(b + i);
    settle(3);
    check(exp_q.size() == 0, "R11 all responses delivered", exp_q.size(), 0);
    #1;
    check(rq_ready == 1, "R9 capacity restored", rq_ready, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule